// File: doc/BRIEF.md
# Fractional-N PLL Power and Relock Sequencer

This block walks the control word of a fractional-N synthesizer through three operations: bring-up, shut-down and reprogramming to a new frequency. Each operation is started by a one-cycle command strobe. The block orders the control-bit changes and waits a fixed settle time before it powers the loop. It then waits a bounded time for lock. At the end it reports through a one-cycle `done` pulse, plus sticky timeout and numerator-mismatch flags.

A reprogram request carries the wanted output rate in kHz. A built-in table of divider settings is searched for an entry whose rate equals that value exactly. The selected integer, numerator, denominator, reference-divider and output-divider fields appear on the divider outputs while the loop is powered down. All microsecond intervals are derived from a clock-cycles-per-microsecond parameter.

Top module: `fpll_seq`

## Requirements
- R1: `ctl_word` bit 2 is bypass, bit 1 is output enable and bit 0 is power-up. No clock edge changes more than one of these bits.
- R2: After reset, `ctl_word`, all divider outputs, `busy`, `done`, `err_timeout` and `warn_mfn` are zero.
- R3: Bring-up from the powered-down state sets bypass, then power-up, then output enable, one bit per cycle. The lock wait starts next. When lock is seen, bypass is cleared and `done` pulses.
- R4: Bring-up while power-up is already set changes no control bit, and `done` pulses on the accepting edge.
- R5: Shut-down clears only power-up, and `done` pulses on the accepting edge.
- R6: Reprogramming clears output enable, then power-up, then bypass, on three consecutive edges. The next edge loads the divider outputs with the selected entry, and output enable and power-up are both low at that point.
- R7: Power-up is set exactly SETTLE_US×CYC_PER_US cycles after the edge that loads the divider outputs.
- R8: If the synchronised lock is not seen within LOCK_US×CYC_PER_US cycles of the lock wait, the operation ends with `err_timeout` set and output enable low.
- R9: When reprogramming locks, output enable is set. On the same edge `warn_mfn` is loaded with the result of comparing `mfn_readback` with the written numerator (high on mismatch).
- R10: A reprogram request whose `req_khz` matches no table entry is ignored. `busy` stays low, no `done` follows, and the control word and divider outputs keep their values.
- R11: `lock_raw` passes through a two-flop synchroniser. A lock that rises on the input is acted on at the third clock edge after it is set up.
- R12: While `busy` is high all commands are ignored. `done` is a one-cycle pulse at the end of every operation. An accepted command clears `err_timeout` and `warn_mfn`.
- R13: Commands that arrive in the same cycle are served by priority: shut-down first, then bring-up, then reprogram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_up | input | 1 | Bring-up strobe |
| cmd_down | input | 1 | Shut-down strobe |
| cmd_rate | input | 1 | Reprogram strobe |
| req_khz | input | 32 | Requested output rate in kHz for reprogramming |
| lock_raw | input | 1 | Asynchronous lock indication from the loop |
| mfn_readback | input | 30 | Numerator value read back from the analog side |
| ctl_word | output | 3 | {bypass, output enable, power-up} |
| div_mfi | output | 9 | Integer multiplier field |
| div_mfn | output | 30 | Fractional numerator field |
| div_mfd | output | 30 | Fractional denominator field |
| div_rdiv | output | 3 | Reference divider field |
| div_odiv | output | 8 | Output divider field |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_timeout | output | 1 | Last operation failed to lock |
| warn_mfn | output | 1 | Last reprogram read back a different numerator |

## Verification
Take the edge that samples a strobe as edge 0, with lock held high long enough. Under that condition `done` rises at edge 0 for shut-down and for a no-op bring-up, at edge 3 for a cold bring-up, and at edge 4+S for a reprogram (S settle cycles). A timeout is reported at edge 2+L from bring-up and at edge 3+S+L from reprogramming. A lock raised just after edge 4 of a bring-up is answered at edge 7. The driver records the expected edge number of each operation together with its expected result. The monitor compares each `done` against that record, so a pulse that is early, late, missing or extra is reported. Intermediate control words and the power-up edge at the end of the settle time are sampled on the falling edge, after the exact edge at which each one is due.

// File: rtl/fpll_seq_pkg.sv
package fpll_seq_pkg;

   localparam int MFI_W     = 9;
   localparam int MFN_W     = 30;
   localparam int MFD_W     = 30;
   localparam int RDIV_W    = 3;
   localparam int ODIV_W    = 8;
   localparam int RATE_W    = 32;
   localparam int MAX_RATES = 8;

   localparam int CTL_PWR = 0;
   localparam int CTL_OEN = 1;
   localparam int CTL_BYP = 2;

   typedef struct packed {
      logic [RATE_W-1:0] khz;
      logic [MFI_W-1:0]  mfi;
      logic [MFN_W-1:0]  mfn;
      logic [MFD_W-1:0]  mfd;
      logic [RDIV_W-1:0] rdiv;
      logic [ODIV_W-1:0] odiv;
   } rate_ent_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_UP_PWR,
      ST_UP_OEN,
      ST_RT_PWR,
      ST_RT_BYP,
      ST_RT_WR,
      ST_SETTLE,
      ST_LOCK,
      ST_DONE
   } seq_state_t;

   function automatic rate_ent_t mk_ent(input int khz, input int mfi, input int mfn,
                                        input int mfd, input int rdiv, input int odiv);
      rate_ent_t e;
      e.khz  = RATE_W'(khz);
      e.mfi  = MFI_W'(mfi);
      e.mfn  = MFN_W'(mfn);
      e.mfd  = MFD_W'(mfd);
      e.rdiv = RDIV_W'(rdiv);
      e.odiv = ODIV_W'(odiv);
      return e;
   endfunction

   // Settings for a 24 MHz reference; lower index wins on duplicates.
   function automatic rate_ent_t rate_entry(input int idx);
      case (idx)
         0:       return mk_ent(600000, 200,  0,   1, 1, 8);
         1:       return mk_ent(480000, 160,  0,   1, 1, 8);
         2:       return mk_ent(750000, 187, 50, 100, 1, 6);
         3:       return mk_ent(320000, 160,  0,   1, 1, 12);
         4:       return mk_ent(368640, 153, 60, 100, 1, 10);
         5:       return mk_ent(1000000, 125, 0,   1, 1, 3);
         6:       return mk_ent(400000, 150,  0,   1, 1, 9);
         default: return mk_ent(288000, 144,  0,   1, 1, 12);
      endcase
   endfunction

endpackage

// File: rtl/fpll_sync.sv
module fpll_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fpll_sync needs at least two stages");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/fpll_timer.sv
module fpll_timer #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);
   if (W < 1) begin : g_bad_width
      $error("fpll_timer width must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/fpll_rate_lut.sv
module fpll_rate_lut
   import fpll_seq_pkg::*;
#(
   parameter int NUM_RATES = 8
) (
   input  logic [RATE_W-1:0] req_khz,
   output logic              hit,
   output rate_ent_t         ent
);
   if (NUM_RATES < 1 || NUM_RATES > MAX_RATES) begin : g_bad_rates
      $error("fpll_rate_lut NUM_RATES out of range");
   end

   logic [NUM_RATES-1:0] match;
   rate_ent_t            rom [NUM_RATES];

   for (genvar g = 0; g < NUM_RATES; g++) begin : g_ent
      assign rom[g]   = rate_entry(g);
      assign match[g] = (req_khz == rom[g].khz);
   end

   always_comb begin
      hit = |match;
      ent = '0;
      for (int i = NUM_RATES - 1; i >= 0; i--) begin
         if (match[i]) ent = rom[i];
      end
   end
endmodule

// File: rtl/fpll_seq.sv
module fpll_seq
   import fpll_seq_pkg::*;
#(
   parameter int CYC_PER_US  = 50,
   parameter int SETTLE_US   = 5,
   parameter int LOCK_US     = 200,
   parameter int SYNC_STAGES = 2,
   parameter int NUM_RATES   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_up,
   input  logic              cmd_down,
   input  logic              cmd_rate,
   input  logic [31:0]       req_khz,
   input  logic              lock_raw,
   input  logic [29:0]       mfn_readback,
   output logic [2:0]        ctl_word,
   output logic [8:0]        div_mfi,
   output logic [29:0]       div_mfn,
   output logic [29:0]       div_mfd,
   output logic [2:0]        div_rdiv,
   output logic [7:0]        div_odiv,
   output logic              busy,
   output logic              done,
   output logic              err_timeout,
   output logic              warn_mfn
);
   localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
   localparam int LOCK_CYC   = CYC_PER_US * LOCK_US;
   localparam int MAX_CYC    = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
   localparam int TMR_W      = $clog2(MAX_CYC + 1);

   if (CYC_PER_US < 1 || SETTLE_US < 1 || LOCK_US < 1) begin : g_bad_time
      $error("fpll_seq timing parameters must be positive");
   end
   if (MFN_W != 30 || MFI_W != 9 || MFD_W != 30 || RDIV_W != 3 || ODIV_W != 8) begin : g_bad_fields
      $error("fpll_seq port widths disagree with the package fields");
   end

   // lock synchroniser (R11)
   logic lock_s;
   fpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(lock_raw), .q(lock_s)
   );

   // rate table search (R10)
   logic      lut_hit;
   rate_ent_t lut_ent;
   fpll_rate_lut #(.NUM_RATES(NUM_RATES)) u_lut (
      .req_khz(req_khz), .hit(lut_hit), .ent(lut_ent)
   );

   // shared interval timer for settle and lock windows
   seq_state_t       state;
   logic [TMR_W-1:0] tmr;
   logic             settle_last, lock_last, tmr_clr, tmr_en;

   assign settle_last = (state == ST_SETTLE) && (tmr == TMR_W'(SETTLE_CYC - 1));
   assign lock_last   = (state == ST_LOCK)   && (tmr == TMR_W'(LOCK_CYC - 1));
   assign tmr_clr     = (state == ST_RT_WR) || (state == ST_UP_OEN) || settle_last;
   assign tmr_en      = (state == ST_SETTLE) || (state == ST_LOCK);

   fpll_timer #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .cnt(tmr)
   );

   rate_ent_t pend;
   logic      op_rate;
   logic [2:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         ctl_q       <= '0;
         pend        <= '0;
         op_rate     <= 1'b0;
         div_mfi     <= '0;
         div_mfn     <= '0;
         div_mfd     <= '0;
         div_rdiv    <= '0;
         div_odiv    <= '0;
         err_timeout <= 1'b0;
         warn_mfn    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cmd_down) begin
                  err_timeout    <= 1'b0;
                  warn_mfn       <= 1'b0;
                  ctl_q[CTL_PWR] <= 1'b0;
                  state          <= ST_DONE;
               end else if (cmd_up) begin
                  err_timeout <= 1'b0;
                  warn_mfn    <= 1'b0;
                  op_rate     <= 1'b0;
                  if (ctl_q[CTL_PWR]) begin
                     state <= ST_DONE;
                  end else begin
                     ctl_q[CTL_BYP] <= 1'b1;
                     state          <= ST_UP_PWR;
                  end
               end else if (cmd_rate && lut_hit) begin
                  err_timeout    <= 1'b0;
                  warn_mfn       <= 1'b0;
                  op_rate        <= 1'b1;
                  pend           <= lut_ent;
                  ctl_q[CTL_OEN] <= 1'b0;
                  state          <= ST_RT_PWR;
               end
            end
            ST_UP_PWR: begin
               ctl_q[CTL_PWR] <= 1'b1;
               state          <= ST_UP_OEN;
            end
            ST_UP_OEN: begin
               ctl_q[CTL_OEN] <= 1'b1;
               state          <= ST_LOCK;
            end
            ST_RT_PWR: begin
               ctl_q[CTL_PWR] <= 1'b0;
               state          <= ST_RT_BYP;
            end
            ST_RT_BYP: begin
               ctl_q[CTL_BYP] <= 1'b0;
               state          <= ST_RT_WR;
            end
            ST_RT_WR: begin
               div_mfi  <= pend.mfi;
               div_mfn  <= pend.mfn;
               div_mfd  <= pend.mfd;
               div_rdiv <= pend.rdiv;
               div_odiv <= pend.odiv;
               state    <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (settle_last) begin
                  ctl_q[CTL_PWR] <= 1'b1;
                  state          <= ST_LOCK;
               end
            end
            ST_LOCK: begin
               if (lock_s) begin
                  if (op_rate) begin
                     ctl_q[CTL_OEN] <= 1'b1;
                     warn_mfn       <= (mfn_readback != div_mfn);
                  end else begin
                     ctl_q[CTL_BYP] <= 1'b0;
                  end
                  state <= ST_DONE;
               end else if (lock_last) begin
                  err_timeout    <= 1'b1;
                  ctl_q[CTL_OEN] <= 1'b0;
                  state          <= ST_DONE;
               end
            end
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign ctl_word = ctl_q;
   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_DONE);
endmodule

// File: rtl/fpll_seq_chk.sv
module fpll_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  ctl_word,
   input logic        done,
   input logic        err_timeout,
   input logic        lock_raw,
   input logic [8:0]  div_mfi,
   input logic [29:0] div_mfn,
   input logic [29:0] div_mfd,
   input logic [2:0]  div_rdiv,
   input logic [7:0]  div_odiv
);
   logic [79:0] div_all;
   assign div_all = {div_mfi, div_mfn, div_mfd, div_rdiv, div_odiv};

   p_one_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ctl_word ^ $past(ctl_word)) <= 1);

   p_byp_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_word[2]) |-> !ctl_word[0]);

   p_oen_needs_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_word[1]) |-> ctl_word[0]);

   p_rate_pwr_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctl_word[0]) && !ctl_word[2]) |-> !ctl_word[1]);

   p_div_write_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_all) |-> (ctl_word[1:0] == 2'b00));

   p_timeout_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_timeout) |-> !ctl_word[1]);

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_lock_synced_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctl_word[2]) && ctl_word[0]) |-> $past(lock_raw, 2));
endmodule

bind fpll_seq fpll_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .done(done),
   .err_timeout(err_timeout), .lock_raw(lock_raw),
   .div_mfi(div_mfi), .div_mfn(div_mfn), .div_mfd(div_mfd),
   .div_rdiv(div_rdiv), .div_odiv(div_odiv)
);

// File: tb/tb_fpll_seq.sv
`timescale 1ns/1ps
module tb_fpll_seq;
   localparam int S  = 250;     // 5 us at 50 cycles/us
   localparam int L  = 10000;   // 200 us
   localparam int WD = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_up = 1'b0, cmd_down = 1'b0, cmd_rate = 1'b0;
   logic [31:0] req_khz = '0;
   logic        lock_raw = 1'b1;
   logic [29:0] mfn_readback = '0;
   logic [2:0]  ctl_word;
   logic [8:0]  div_mfi;
   logic [29:0] div_mfn, div_mfd;
   logic [2:0]  div_rdiv;
   logic [7:0]  div_odiv;
   logic        busy, done, err_timeout, warn_mfn;

   always #10 clk = ~clk;

   fpll_seq dut (
      .clk(clk), .rst_n(rst_n), .cmd_up(cmd_up), .cmd_down(cmd_down),
      .cmd_rate(cmd_rate), .req_khz(req_khz), .lock_raw(lock_raw),
      .mfn_readback(mfn_readback), .ctl_word(ctl_word), .div_mfi(div_mfi),
      .div_mfn(div_mfn), .div_mfd(div_mfd), .div_rdiv(div_rdiv),
      .div_odiv(div_odiv), .busy(busy), .done(done),
      .err_timeout(err_timeout), .warn_mfn(warn_mfn)
   );

   int unsigned cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int unsigned acc;
      int          lat;
      logic [2:0]  ctl;
      logic        err;
      logic        warn;
      logic [79:0] div;
      string       tag;
   } exp_t;
   exp_t q[$];

   function automatic logic [79:0] tab(input int khz);
      case (khz)
         600000:  return {9'd200, 30'd0,  30'd1,   3'd1, 8'd8};
         480000:  return {9'd160, 30'd0,  30'd1,   3'd1, 8'd8};
         750000:  return {9'd187, 30'd50, 30'd100, 3'd1, 8'd6};
         320000:  return {9'd160, 30'd0,  30'd1,   3'd1, 8'd12};
         368640:  return {9'd153, 30'd60, 30'd100, 3'd1, 8'd10};
         default: return '0;
      endcase
   endfunction

   function automatic logic [79:0] cur_div();
      return {div_mfi, div_mfn, div_mfd, div_rdiv, div_odiv};
   endfunction

   task automatic chk(input string req, input string what, input logic [79:0] act,
                      input logic [79:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: every done is matched against the oldest expected item
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R12 unexpected done: actual 1 expected 0");
         end else begin
            exp_t e;
            e = q.pop_front();
            if (e.lat >= 0) chk(e.tag, "done edge", 80'(cyc), 80'(e.acc + e.lat));
            chk(e.tag, "ctl_word", 80'(ctl_word), 80'(e.ctl));
            chk(e.tag, "err_timeout", 80'(err_timeout), 80'(e.err));
            chk(e.tag, "warn_mfn", 80'(warn_mfn), 80'(e.warn));
            chk(e.tag, "divider", cur_div(), e.div);
         end
      end
   end

   // driver: strobes a command for one cycle and pushes the expected outcome
   task automatic issue(input bit up, input bit dn, input bit rt, input int khz,
                        input int lat, input logic [2:0] ectl, input bit eerr,
                        input bit ewarn, input logic [79:0] ediv, input string tag);
      exp_t e;
      @(negedge clk);
      cmd_up = up; cmd_down = dn; cmd_rate = rt; req_khz = 32'(khz);
      e.acc = cyc + 1; e.lat = lat; e.ctl = ectl; e.err = eerr; e.warn = ewarn;
      e.div = ediv; e.tag = tag;
      q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      cmd_up = 0; cmd_down = 0; cmd_rate = 0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic step_chk(input string req, input logic [2:0] exp);
      @(negedge clk);
      chk(req, "ctl step", 80'(ctl_word), 80'(exp));
   endtask

   always @(posedge clk) begin
      if (cyc == WD) begin
         n_chk++; n_bad++;
         $display("FAIL R12 watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2 reset state
      chk("R2", "ctl_word", 80'(ctl_word), 80'(0));
      chk("R2", "divider", cur_div(), 80'(0));
      chk("R2", "flags", 80'({busy, done, err_timeout, warn_mfn}), 80'(0));
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R3 cold bring-up, R1 bit positions: bypass=bit2, oen=bit1, pwr=bit0
      issue(1, 0, 0, 0, 3, 3'b011, 0, 0, 80'(0), "R3");
      chk("R3", "ctl after edge0", 80'(ctl_word), 80'(3'b100));
      step_chk("R3", 3'b101);
      step_chk("R1", 3'b111);
      wait_idle();

      // R4 bring-up while powered
      issue(1, 0, 0, 0, 0, 3'b011, 0, 0, 80'(0), "R4");
      wait_idle();

      // R6 R7 R9 reprogram with matching numerator
      mfn_readback = 30'd50;
      issue(0, 0, 1, 750000, 4 + S, 3'b011, 0, 0, tab(750000), "R9");
      chk("R6", "oen cleared", 80'(ctl_word), 80'(3'b001));
      step_chk("R6", 3'b000);
      step_chk("R6", 3'b000);
      @(negedge clk);
      chk("R6", "divider loaded", cur_div(), tab(750000));
      repeat (S - 1) @(negedge clk);
      chk("R7", "pwr still off", 80'(ctl_word[0]), 80'(0));
      @(negedge clk);
      chk("R7", "pwr set", 80'(ctl_word), 80'(3'b001));
      wait_idle();

      // R9 numerator mismatch
      mfn_readback = 30'd61;
      issue(0, 0, 1, 368640, 4 + S, 3'b011, 0, 1, tab(368640), "R9");
      wait_idle();

      // R12 commands during busy ignored, warn cleared on accept
      mfn_readback = 30'd0;
      issue(0, 0, 1, 480000, 4 + S, 3'b011, 0, 0, tab(480000), "R12");
      repeat (4) @(negedge clk);
      cmd_down = 1; cmd_up = 1;
      @(negedge clk);
      cmd_down = 0; cmd_up = 0;
      wait_idle();

      // R10 unmatched rate ignored
      @(negedge clk);
      cmd_rate = 1; req_khz = 32'd123456;
      @(negedge clk);
      cmd_rate = 0;
      chk("R10", "busy", 80'(busy), 80'(0));
      @(negedge clk);
      chk("R10", "busy later", 80'(busy), 80'(0));
      chk("R10", "ctl_word", 80'(ctl_word), 80'(3'b011));
      chk("R10", "divider", cur_div(), tab(480000));

      // R5 shut-down
      issue(0, 1, 0, 0, 0, 3'b010, 0, 0, tab(480000), "R5");
      wait_idle();

      // R8 bring-up timeout
      lock_raw = 1'b0;
      repeat (3) @(negedge clk);
      issue(1, 0, 0, 0, 2 + L, 3'b101, 1, 0, tab(480000), "R8");
      wait_idle();

      // R8 reprogram timeout, R6 bypass clearing step
      issue(0, 0, 1, 320000, 3 + S + L, 3'b001, 1, 0, tab(320000), "R8");
      step_chk("R6", 3'b100);
      step_chk("R6", 3'b000);
      wait_idle();

      // R11 lock through synchroniser
      issue(0, 1, 0, 0, 0, 3'b000, 0, 0, tab(320000), "R5");
      wait_idle();
      issue(1, 0, 0, 0, 7, 3'b011, 0, 0, tab(320000), "R11");
      repeat (4) @(negedge clk);
      lock_raw = 1'b1;
      wait_idle();

      // R13 priority
      issue(1, 1, 0, 0, 0, 3'b010, 0, 0, tab(320000), "R13");
      wait_idle();
      issue(1, 0, 1, 600000, 3, 3'b011, 0, 0, tab(320000), "R13");
      wait_idle();

      repeat (5) @(negedge clk);
      chk("R12", "pending items", 80'(q.size()), 80'(0));
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule